// File: doc/BRIEF.md
# Eight-bit accumulator ALU with status flags

This block is the data path of a small accumulator processor. It keeps three byte registers (the accumulator and two index registers) and four status flags: carry, zero, overflow and negative. Each cycle it takes a 5-bit operation code, a data byte and a write strobe. It works out the new register values and flags, and a result byte for read-modify-write operations, all in the same cycle. The registers and flags take the new values on the next rising clock edge when the strobe is high.

The operations are loads, add and subtract with carry, AND/OR/XOR into the accumulator, shifts and rotates of the data byte, a bit test, compares against any of the three registers, increment and decrement of the data byte, and the combined operations. A combined operation first shifts or steps the data byte and then feeds that intermediate byte to an accumulator operation, all in one pass. Subtraction is addition of the inverted byte. Decimal arithmetic, addressing and memory are handled outside the block.

Top module: `acc_alu`

## Requirements
- R1: While rst_n is low, and after it, acc_o, x_o, y_o and flags_o are all zero. flags_o bit 3 is N, bit 2 is V, bit 1 is Z and bit 0 is C.
- R2: Codes 0x00, 0x01 and 0x02 load operand_i into the accumulator, X and Y respectively. Z is set when the byte is zero, N takes bit 7, and C and V keep their values. For any operation that is not read-modify-write, result_o is 0x00.
- R3: Code 0x03 sets the accumulator to (A + operand + C) mod 256. C becomes the unsigned carry out. V is set when the signed sum leaves the range -128..127. Z and N follow the new accumulator.
- R4: Code 0x04 behaves exactly as code 0x03 applied to operand XOR 0xFF, so a clear C takes one more away.
- R5: Codes 0x05, 0x06 and 0x07 replace the accumulator with A AND, OR and XOR the operand. Z and N follow the result, and C and V keep their values.
- R6: Codes 0x08 (shift left), 0x09 (shift right), 0x0A (rotate left through C) and 0x0B (rotate right through C) return the shifted operand on result_o. The bit shifted out goes to C, Z and N follow the returned byte (so shift right always clears N), V keeps its value, and the accumulator is unchanged.
- R7: Code 0x0C leaves the accumulator unchanged. It sets Z when A AND operand is zero, copies operand bit 6 into V and copies operand bit 7 into N.
- R8: Codes 0x0D, 0x0E and 0x0F compare A, X and Y (u) with the operand (v). C is set when u >= v unsigned, Z is set when they are equal, and N takes bit 7 of (u - v) mod 256. V and all registers are unchanged.
- R9: Codes 0x10 and 0x11 return operand+1 and operand-1 (mod 256) on result_o. Z and N follow that byte. C, V and the registers are unchanged.
- R10: Codes 0x12 (shift left, then OR), 0x13 (rotate left, then AND) and 0x14 (shift right, then XOR) return the shifted byte on result_o. C takes the shifted-out bit, the accumulator is combined with the shifted byte, and Z and N follow the new accumulator.
- R11: Code 0x15 rotates right and then adds the rotated byte using the carry the rotate produced. Code 0x16 decrements and then compares A with the decremented byte. Code 0x17 increments and then subtracts the incremented byte. Each returns its intermediate byte on result_o.
- R12: Code 0x18 loads the operand into both the accumulator and X, with load flags.
- R13: With wr_en_i low, no register or flag changes, while result_o still shows the value for the current inputs.
- R14: Codes 0x19 to 0x1F change no register or flag, even with wr_en_i high, and give result_o 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 5 | Operation code |
| operand_i | input | 8 | Data byte |
| wr_en_i | input | 1 | Commit strobe |
| result_o | output | 8 | Read-modify-write byte (combinational) |
| acc_o | output | 8 | Accumulator |
| x_o | output | 8 | X index register |
| y_o | output | 8 | Y index register |
| flags_o | output | 4 | {N, V, Z, C} |

## Verification
result_o is combinational: it is due in the same cycle the operation code and operand are applied. The bench drives inputs on the falling edge and samples result_o shortly afterwards, before the next rising edge. Registers and flags pass through one register stage, so they are due one rising edge after the operation. The bench reads them just after that edge, before the next stimulus is applied. A reference model in the bench, written with integer arithmetic, advances in step with each committed operation.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int unsigned DW  = 8;
  localparam int unsigned OPW = 5;

  typedef logic [DW-1:0] byte_t;

  typedef enum logic [OPW-1:0] {
    OP_LD_A  = 5'h00, OP_LD_X  = 5'h01, OP_LD_Y  = 5'h02,
    OP_ADD   = 5'h03, OP_SUB   = 5'h04,
    OP_AND   = 5'h05, OP_OR    = 5'h06, OP_XOR   = 5'h07,
    OP_SHL   = 5'h08, OP_SHR   = 5'h09, OP_RTL   = 5'h0A, OP_RTR = 5'h0B,
    OP_BIT   = 5'h0C,
    OP_CMP_A = 5'h0D, OP_CMP_X = 5'h0E, OP_CMP_Y = 5'h0F,
    OP_INC   = 5'h10, OP_DEC   = 5'h11,
    OP_SHL_OR = 5'h12, OP_RTL_AND = 5'h13, OP_SHR_XOR = 5'h14,
    OP_RTR_ADD = 5'h15, OP_DEC_CMP = 5'h16, OP_INC_SUB = 5'h17,
    OP_LD_AX = 5'h18
  } op_e;

  typedef enum logic [2:0] {
    PRE_PASS, PRE_SHL, PRE_SHR, PRE_RTL, PRE_RTR, PRE_INC, PRE_DEC
  } pre_e;

  typedef enum logic [2:0] {
    POST_NONE, POST_LOAD, POST_ADD, POST_AND, POST_OR, POST_XOR, POST_BIT, POST_CMP
  } post_e;

  typedef enum logic [1:0] { SEL_A, SEL_X, SEL_Y } sel_e;

  typedef struct packed {
    logic  valid;
    pre_e  pre;
    post_e post;
    logic  inv;
    sel_e  cmp_sel;
    logic  wr_a;
    logic  wr_x;
    logic  wr_y;
    logic  rmw;
  } ctrl_t;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } flags_t;

  typedef struct packed {
    byte_t sum;
    logic  c;
    logic  v;
  } add_t;

  function automatic add_t add_bytes(byte_t a, byte_t b, logic cin);
    logic [DW:0] wide;
    add_t r;
    wide  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    r.sum = wide[DW-1:0];
    r.c   = wide[DW];
    r.v   = (a[DW-1] == b[DW-1]) && (r.sum[DW-1] != a[DW-1]);
    return r;
  endfunction

  // returns {c, z, n}
  function automatic logic [2:0] cmp_bytes(byte_t u, byte_t v);
    byte_t diff;
    diff = u - v;
    return {u >= v, u == v, diff[DW-1]};
  endfunction
endpackage

// File: rtl/acc_alu_dec.sv
module acc_alu_dec
  import acc_alu_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  output ctrl_t          ctrl_o
);
  always_comb begin
    ctrl_o         = '0;
    ctrl_o.valid   = 1'b1;
    ctrl_o.pre     = PRE_PASS;
    ctrl_o.post    = POST_NONE;
    ctrl_o.cmp_sel = SEL_A;
    case (op_e'(op_i))
      OP_LD_A:    begin ctrl_o.post = POST_LOAD; ctrl_o.wr_a = 1'b1; end
      OP_LD_X:    begin ctrl_o.post = POST_LOAD; ctrl_o.wr_x = 1'b1; end
      OP_LD_Y:    begin ctrl_o.post = POST_LOAD; ctrl_o.wr_y = 1'b1; end
      OP_ADD:     begin ctrl_o.post = POST_ADD; ctrl_o.wr_a = 1'b1; end
      OP_SUB:     begin ctrl_o.post = POST_ADD; ctrl_o.inv = 1'b1; ctrl_o.wr_a = 1'b1; end
      OP_AND:     begin ctrl_o.post = POST_AND; ctrl_o.wr_a = 1'b1; end
      OP_OR:      begin ctrl_o.post = POST_OR;  ctrl_o.wr_a = 1'b1; end
      OP_XOR:     begin ctrl_o.post = POST_XOR; ctrl_o.wr_a = 1'b1; end
      OP_SHL:     begin ctrl_o.pre = PRE_SHL; ctrl_o.rmw = 1'b1; end
      OP_SHR:     begin ctrl_o.pre = PRE_SHR; ctrl_o.rmw = 1'b1; end
      OP_RTL:     begin ctrl_o.pre = PRE_RTL; ctrl_o.rmw = 1'b1; end
      OP_RTR:     begin ctrl_o.pre = PRE_RTR; ctrl_o.rmw = 1'b1; end
      OP_BIT:     ctrl_o.post = POST_BIT;
      OP_CMP_A:   ctrl_o.post = POST_CMP;
      OP_CMP_X:   begin ctrl_o.post = POST_CMP; ctrl_o.cmp_sel = SEL_X; end
      OP_CMP_Y:   begin ctrl_o.post = POST_CMP; ctrl_o.cmp_sel = SEL_Y; end
      OP_INC:     begin ctrl_o.pre = PRE_INC; ctrl_o.rmw = 1'b1; end
      OP_DEC:     begin ctrl_o.pre = PRE_DEC; ctrl_o.rmw = 1'b1; end
      OP_SHL_OR:  begin ctrl_o.pre = PRE_SHL; ctrl_o.post = POST_OR;  ctrl_o.wr_a = 1'b1; ctrl_o.rmw = 1'b1; end
      OP_RTL_AND: begin ctrl_o.pre = PRE_RTL; ctrl_o.post = POST_AND; ctrl_o.wr_a = 1'b1; ctrl_o.rmw = 1'b1; end
      OP_SHR_XOR: begin ctrl_o.pre = PRE_SHR; ctrl_o.post = POST_XOR; ctrl_o.wr_a = 1'b1; ctrl_o.rmw = 1'b1; end
      OP_RTR_ADD: begin ctrl_o.pre = PRE_RTR; ctrl_o.post = POST_ADD; ctrl_o.wr_a = 1'b1; ctrl_o.rmw = 1'b1; end
      OP_DEC_CMP: begin ctrl_o.pre = PRE_DEC; ctrl_o.post = POST_CMP; ctrl_o.rmw = 1'b1; end
      OP_INC_SUB: begin ctrl_o.pre = PRE_INC; ctrl_o.post = POST_ADD; ctrl_o.inv = 1'b1;
                        ctrl_o.wr_a = 1'b1; ctrl_o.rmw = 1'b1; end
      OP_LD_AX:   begin ctrl_o.post = POST_LOAD; ctrl_o.wr_a = 1'b1; ctrl_o.wr_x = 1'b1; end
      default:    ctrl_o.valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/acc_alu_pre.sv
module acc_alu_pre
  import acc_alu_pkg::*;
(
  input  byte_t din_i,
  input  logic  cin_i,
  input  pre_e  sel_i,
  output byte_t dout_o,
  output logic  cout_o
);
  always_comb begin
    dout_o = din_i;
    cout_o = cin_i;
    case (sel_i)
      PRE_SHL: begin dout_o = {din_i[DW-2:0], 1'b0};  cout_o = din_i[DW-1]; end
      PRE_SHR: begin dout_o = {1'b0, din_i[DW-1:1]};  cout_o = din_i[0];    end
      PRE_RTL: begin dout_o = {din_i[DW-2:0], cin_i}; cout_o = din_i[DW-1]; end
      PRE_RTR: begin dout_o = {cin_i, din_i[DW-1:1]}; cout_o = din_i[0];    end
      PRE_INC: dout_o = din_i + byte_t'(1);
      PRE_DEC: dout_o = din_i - byte_t'(1);
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_post.sv
module acc_alu_post
  import acc_alu_pkg::*;
(
  input  post_e  sel_i,
  input  byte_t  src_i,
  input  byte_t  acc_i,
  input  byte_t  cmp_val_i,
  input  flags_t flags_i,
  input  logic   mid_c_i,
  output byte_t  val_o,
  output flags_t flags_o
);
  add_t       sum_w;
  logic [2:0] cmp_w;

  assign sum_w = add_bytes(acc_i, src_i, mid_c_i);
  assign cmp_w = cmp_bytes(cmp_val_i, src_i);

  always_comb begin
    flags_o   = flags_i;
    flags_o.c = mid_c_i;
    val_o     = src_i;
    case (sel_i)
      POST_LOAD: val_o = src_i;
      POST_AND:  val_o = acc_i & src_i;
      POST_OR:   val_o = acc_i | src_i;
      POST_XOR:  val_o = acc_i ^ src_i;
      POST_ADD:  begin val_o = sum_w.sum; flags_o.c = sum_w.c; flags_o.v = sum_w.v; end
      POST_BIT:  val_o = acc_i;
      POST_CMP:  val_o = acc_i;
      default:   val_o = src_i;
    endcase
    case (sel_i)
      POST_BIT: begin
        flags_o.z = ((acc_i & src_i) == '0);
        flags_o.v = src_i[DW-2];
        flags_o.n = src_i[DW-1];
      end
      POST_CMP: begin
        flags_o.c = cmp_w[2];
        flags_o.z = cmp_w[1];
        flags_o.n = cmp_w[0];
      end
      default: begin
        flags_o.z = (val_o == '0);
        flags_o.n = val_o[DW-1];
      end
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] op_i,
  input  logic [DW-1:0]  operand_i,
  input  logic           wr_en_i,
  output logic [DW-1:0]  result_o,
  output logic [DW-1:0]  acc_o,
  output logic [DW-1:0]  x_o,
  output logic [DW-1:0]  y_o,
  output logic [3:0]     flags_o
);
  ctrl_t  ctrl_w;
  byte_t  acc_q, x_q, y_q;
  flags_t flags_q, flags_nxt_w;
  byte_t  mid_w, src_w, post_w, cmp_val_w;
  logic   mid_c_w;
  logic   op_valid_w;
  logic   commit_w;

  acc_alu_dec u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl_w)
  );

  acc_alu_pre u_pre (
    .din_i  (operand_i),
    .cin_i  (flags_q.c),
    .sel_i  (ctrl_w.pre),
    .dout_o (mid_w),
    .cout_o (mid_c_w)
  );

  assign src_w = ctrl_w.inv ? ~mid_w : mid_w;

  always_comb begin
    case (ctrl_w.cmp_sel)
      SEL_X:   cmp_val_w = x_q;
      SEL_Y:   cmp_val_w = y_q;
      default: cmp_val_w = acc_q;
    endcase
  end

  acc_alu_post u_post (
    .sel_i     (ctrl_w.post),
    .src_i     (src_w),
    .acc_i     (acc_q),
    .cmp_val_i (cmp_val_w),
    .flags_i   (flags_q),
    .mid_c_i   (mid_c_w),
    .val_o     (post_w),
    .flags_o   (flags_nxt_w)
  );

  assign op_valid_w = ctrl_w.valid;
  assign commit_w   = wr_en_i & op_valid_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      x_q     <= '0;
      y_q     <= '0;
      flags_q <= '0;
    end else if (commit_w) begin
      if (ctrl_w.wr_a) acc_q <= post_w;
      if (ctrl_w.wr_x) x_q   <= post_w;
      if (ctrl_w.wr_y) y_q   <= post_w;
      flags_q <= flags_nxt_w;
    end
  end

  assign result_o = ctrl_w.rmw ? mid_w : '0;
  assign acc_o    = acc_q;
  assign x_o      = x_q;
  assign y_o      = y_q;
  assign flags_o  = flags_q;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic [OPW-1:0] op_i,
  input logic [DW-1:0]  operand_i,
  input logic           wr_en_i,
  input logic [DW-1:0]  acc_o,
  input logic [DW-1:0]  x_o,
  input logic [DW-1:0]  y_o,
  input logic [3:0]     flags_o,
  input logic           op_valid_w
);
  // R13
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable({acc_o, x_o, y_o, flags_o}));

  // R14
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid_w |=> $stable({acc_o, x_o, y_o, flags_o}));

  // R7
  bit_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && op_i == OP_BIT) |=>
      $stable(acc_o) && flags_o[2] == $past(operand_i[DW-2]) && flags_o[3] == $past(operand_i[DW-1]));

  // R2
  load_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && op_i == OP_LD_A) |=> acc_o == $past(operand_i) && flags_o[1] == (acc_o == '0));

  // R6
  shift_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && op_i == OP_SHR) |=> !flags_o[3] && flags_o[0] == $past(operand_i[0]) && $stable(acc_o));

  // R8
  compare_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (op_i == OP_CMP_A || op_i == OP_CMP_X || op_i == OP_CMP_Y)) |=>
      $stable({acc_o, x_o, y_o, flags_o[2]}));
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_i       (op_i),
  .operand_i  (operand_i),
  .wr_en_i    (wr_en_i),
  .acc_o      (acc_o),
  .x_o        (x_o),
  .y_o        (y_o),
  .flags_o    (flags_o),
  .op_valid_w (op_valid_w)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] operand_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] result_o, acc_o, x_o, y_o;
  logic [3:0] flags_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  int m_a = 0, m_x = 0, m_y = 0;
  bit mn = 0, mv = 0, mz = 0, mc = 0;

  always #5 clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .operand_i(operand_i), .wr_en_i(wr_en_i),
    .result_o(result_o), .acc_o(acc_o), .x_o(x_o), .y_o(y_o), .flags_o(flags_o)
  );

  task automatic check(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic add_model(input int a, input int b, input bit ci,
                           output int r, output bit co, output bit vo);
    int s, sa, sb;
    s  = a + b + (ci ? 1 : 0);
    r  = s % 256;
    co = (s > 255);
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    s  = sa + sb + (ci ? 1 : 0);
    vo = (s > 127) || (s < -128);
  endtask

  task automatic check_state(input string tag);
    check(tag, "acc", int'(acc_o), m_a);
    check(tag, "x", int'(x_o), m_x);
    check(tag, "y", int'(y_o), m_y);
    check(tag, "flags", int'(flags_o), {mn, mv, mz, mc});
  endtask

  task automatic step(input int op, input int d, input bit we, input string tag);
    int na, nx, ny, res, u, t;
    bit fn, fv, fz, fc, c1;
    na = m_a; nx = m_x; ny = m_y; res = 0;
    fn = mn; fv = mv; fz = mz; fc = mc;
    case (op)
      0, 1, 2, 24: begin
        if (op == 0 || op == 24) na = d;
        if (op == 1 || op == 24) nx = d;
        if (op == 2) ny = d;
        fz = (d == 0); fn = (d >= 128);
      end
      3, 4: begin
        add_model(m_a, (op == 4) ? 255 - d : d, mc, t, fc, fv);
        na = t; fz = (t == 0); fn = (t >= 128);
      end
      5, 6, 7: begin
        na = (op == 5) ? (m_a & d) : (op == 6) ? (m_a | d) : (m_a ^ d);
        fz = (na == 0); fn = (na >= 128);
      end
      8, 9, 10, 11, 16, 17: begin
        case (op)
          8:  begin res = (d * 2) % 256; fc = (d >= 128); end
          9:  begin res = d / 2; fc = (d % 2 == 1); end
          10: begin res = (d * 2 + (mc ? 1 : 0)) % 256; fc = (d >= 128); end
          11: begin res = d / 2 + (mc ? 128 : 0); fc = (d % 2 == 1); end
          16: res = (d + 1) % 256;
          default: res = (d + 255) % 256;
        endcase
        fz = (res == 0); fn = (res >= 128);
      end
      12: begin fz = ((m_a & d) == 0); fv = ((d / 64) % 2 == 1); fn = (d >= 128); end
      13, 14, 15: begin
        u  = (op == 13) ? m_a : (op == 14) ? m_x : m_y;
        fc = (u >= d); fz = (u == d); fn = (((u - d + 256) % 256) >= 128);
      end
      18, 19, 20: begin
        case (op)
          18: begin res = (d * 2) % 256; fc = (d >= 128); na = m_a | res; end
          19: begin res = (d * 2 + (mc ? 1 : 0)) % 256; fc = (d >= 128); na = m_a & res; end
          default: begin res = d / 2; fc = (d % 2 == 1); na = m_a ^ res; end
        endcase
        fz = (na == 0); fn = (na >= 128);
      end
      21: begin
        res = d / 2 + (mc ? 128 : 0); c1 = (d % 2 == 1);
        add_model(m_a, res, c1, t, fc, fv);
        na = t; fz = (t == 0); fn = (t >= 128);
      end
      22: begin
        res = (d + 255) % 256;
        fc = (m_a >= res); fz = (m_a == res); fn = (((m_a - res + 256) % 256) >= 128);
      end
      23: begin
        res = (d + 1) % 256;
        add_model(m_a, 255 - res, mc, t, fc, fv);
        na = t; fz = (t == 0); fn = (t >= 128);
      end
      default: ;
    endcase
    @(negedge clk);
    op_i = op[4:0]; operand_i = d[7:0]; wr_en_i = we;
    #2;
    check(tag, "result", int'(result_o), res);
    @(posedge clk);
    #2;
    if (we && op <= 24) begin
      m_a = na; m_x = nx; m_y = ny; mn = fn; mv = fv; mz = fz; mc = fc;
    end
    check_state(tag);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0; wr_en_i = 1'b0;
    @(posedge clk); #2;
    m_a = 0; m_x = 0; m_y = 0; mn = 0; mv = 0; mz = 0; mc = 0;
    check_state(tag);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_loads;
    step(0, 8'h80, 1, "R2 lda neg");
    step(1, 8'h00, 1, "R2 ldx zero");
    step(2, 8'h7F, 1, "R2 ldy pos");
  endtask

  task automatic t_add_sub;
    step(0, 8'h50, 1, "R3 setup");
    step(3, 8'h50, 1, "R3 signed ovf");
    step(0, 8'hFF, 1, "R3 setup");
    step(3, 8'h01, 1, "R3 carry out zero");
    step(3, 8'h00, 1, "R3 carry in");
    step(4, 8'h30, 1, "R4 clear carry extra");
    step(4, 8'hF0, 1, "R4 borrow");
    step(0, 8'h80, 1, "R4 setup");
    step(4, 8'h01, 1, "R4 signed ovf");
  endtask

  task automatic t_logic;
    step(0, 8'hAA, 1, "R5 setup");
    step(5, 8'h0F, 1, "R5 and");
    step(6, 8'h81, 1, "R5 or");
    step(7, 8'h8B, 1, "R5 xor zero");
  endtask

  task automatic t_shift;
    step(8, 8'h98, 1, "R6 shl");
    step(9, 8'h81, 1, "R6 shr");
    step(10, 8'h40, 1, "R6 rol cin");
    step(11, 8'h01, 1, "R6 ror");
    step(11, 8'h00, 1, "R6 ror cin");
  endtask

  task automatic t_bit_cmp;
    step(0, 8'h18, 1, "R7 setup");
    step(12, 8'hE0, 1, "R7 bit zero");
    step(12, 8'h3F, 1, "R7 bit nonzero");
    step(1, 8'h40, 1, "R8 setup x");
    step(2, 8'h05, 1, "R8 setup y");
    step(13, 8'h18, 1, "R8 cmp equal");
    step(13, 8'h19, 1, "R8 cmp less");
    step(14, 8'h30, 1, "R8 cpx greater");
    step(15, 8'hFF, 1, "R8 cpy less");
  endtask

  task automatic t_step;
    step(16, 8'hFF, 1, "R9 inc wrap");
    step(17, 8'h81, 1, "R9 dec");
    step(17, 8'h00, 1, "R9 dec wrap");
  endtask

  task automatic t_fused;
    step(0, 8'h01, 1, "R10 setup");
    step(18, 8'hC0, 1, "R10 shl or");
    step(19, 8'h7F, 1, "R10 rol and");
    step(20, 8'h03, 1, "R10 shr xor");
    step(0, 8'h7F, 1, "R11 setup");
    step(21, 8'h03, 1, "R11 ror add");
    step(22, 8'h01, 1, "R11 dec cmp");
    step(23, 8'h0F, 1, "R11 inc sub");
    step(24, 8'h9C, 1, "R12 load a and x");
    step(24, 8'h00, 1, "R12 load zero");
  endtask

  task automatic t_hold;
    step(0, 8'h00, 0, "R13 no write load");
    step(3, 8'hFF, 0, "R13 no write add");
    step(8, 8'h81, 0, "R13 no write shl result");
    for (int k = 25; k < 32; k++) step(k, 8'h5A, 1, "R14 undefined code");
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #2;
    check_state("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    t_loads();
    t_add_sub();
    t_logic();
    t_shift();
    t_bit_cmp();
    t_step();
    t_fused();
    t_hold();
    step(24, 8'hC3, 1, "R1 setup");
    step(3, 8'hC3, 1, "R1 setup carry");
    do_reset("R1 reset mid run");
    step(13, 8'h00, 1, "R1 after reset");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule